// File: doc/BRIEF.md
# Programmable Serial Character Transmitter

This block sends one character at a time over a single serial line. The host first loads a character into a holding register while the transmitter is idle. A start strobe then launches a frame. Each frame is a low start bit, 5 to 9 data bits sent least significant bit first, an optional odd or even parity bit, and one or two high stop bits. The frame shape, the synchronous-mode enable and the baud divisor are all sampled when the frame starts.

A programmable divider sets the bit period in clock cycles. In synchronous mode the block also drives a bit clock next to the data. That clock is high for the first half of every bit and low for the second half, so a receiver can sample on its falling edge. The clock stays symmetric for odd divisors because half-cycle steps are taken on the falling edge of the system clock. In asynchronous mode only the data line moves.

Progress is reported through a busy flag, a sticky completion flag and a one-cycle interrupt pulse. The expected host sequence is: wait for idle, load the character, strobe start, then wait for completion.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is high and `bit_clk` is low. After reset `busy`, `done` and `irq` are also low.
- R2: While idle, a `load` pulse captures `load_data` and clears `done`. A later `start` pulse launches a frame, and `txd` goes low (the start bit) on the clock edge that samples `start`.
- R3: The number of data bits is set by `len_sel`: codes 0,1,2,3,4 give 5,6,7,8,9 bits, and codes 5 to 7 give 9 bits. Data bits follow the start bit, least significant bit first.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_odd`=0 the data bits plus the parity bit hold an even number of ones. With `par_odd`=1 they hold an odd number.
- R5: One high stop bit ends the frame, or two when `two_stop` is 1.
- R6: Every bit lasts `divisor` clock cycles, and a `divisor` below 2 counts as 2. The divisor and all frame settings are sampled at the start edge.
- R7: `busy` rises on the start edge and falls at the end of the last stop bit. While `busy` is high, `load` and `start` have no effect.
- R8: At the end of the last stop bit, `done` goes high and `irq` pulses for exactly one cycle. `done` stays high until the next accepted `load`.
- R9: With `sync_en` sampled as 1, `bit_clk` is high for the first `divisor`/2 clock periods of each bit and low for the rest; an odd divisor gives a half-period step, taken on the falling clock edge. With `sync_en` sampled as 0, `bit_clk` stays low.
- R10: A `start` is accepted only while a loaded character is pending, and each accepted start uses up that character. If `start` and `load` arrive in the same idle cycle with a character pending, the start wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture `load_data` into the holding register |
| load_data | input | 9 | Character to send, bit 0 sent first |
| start | input | 1 | Launch a frame from the held character |
| len_sel | input | 3 | Data length code (R3) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| sync_en | input | 1 | Drive the bit clock during frames |
| divisor | input | DIV_W | Clock cycles per bit |
| txd | output | 1 | Serial data line |
| bit_clk | output | 1 | Bit clock in synchronous mode |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
`txd`, `busy`, `done` and `irq` are registered on the same edge that samples a strobe or ends a bit. The bench's reference model therefore advances on each rising edge, and the model is compared with the ports 1 ns after that edge. `bit_clk` can also change on a falling edge when the divisor is odd, so it is compared again 1 ns after each falling edge. On the rising edge it is expected to be the AND of the current and the previous half-bit phase. Inputs are driven on falling edges, so every strobe is seen by exactly one rising edge.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int MAX_DATA  = 9;
  localparam int FRAME_MAX = MAX_DATA + 4;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic [2:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/tx_frame_builder.sv
module tx_frame_builder
  import serial_tx_pkg::*;
(
  input  frame_cfg_t             cfg,
  input  logic [MAX_DATA-1:0]    data,
  output logic [FRAME_MAX-1:0]   frame,
  output logic [CNT_W-1:0]       nbits
);
  logic [3:0]           dlen;
  logic [MAX_DATA-1:0]  masked;
  logic [FRAME_MAX-1:0] dext;
  logic                 par_bit;

  assign dlen = (cfg.len_sel > 3'd4) ? 4'd9 : 4'(cfg.len_sel) + 4'd5;
  assign dext = FRAME_MAX'(data);

  for (genvar g = 0; g < MAX_DATA; g++) begin : g_mask
    assign masked[g] = data[g] & (g < int'(dlen));
  end

  assign par_bit = (^masked) ^ cfg.par_odd;

  always_comb begin
    frame = '1;
    for (int i = 0; i < FRAME_MAX; i++) begin
      if (i == 0)
        frame[i] = 1'b0;
      else if (i <= int'(dlen))
        frame[i] = dext[i-1];
      else if (i == int'(dlen) + 1 && cfg.par_en)
        frame[i] = par_bit;
    end
  end

  assign nbits = CNT_W'(32'(dlen) + 2 + 32'(cfg.par_en) + 32'(cfg.two_stop));
endmodule

// File: rtl/tx_baud_phase.sv
module tx_baud_phase #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [DIV_W-1:0] div_in,
  input  logic             sync_in,
  input  logic             busy_q,
  input  logic             busy_d,
  output logic             bit_end,
  output logic             bit_clk
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [DIV_W-1:0] div_q, div_eff, div_sel, cnt_q, cnt_d, hi_len;
  logic             sync_q, sync_sel, p_q, n_q;

  assign div_eff  = (div_in < DIV_MIN) ? DIV_MIN : div_in;
  assign div_sel  = accept ? div_eff : div_q;
  assign sync_sel = accept ? sync_in : sync_q;
  assign hi_len   = DIV_W'(({1'b0, div_sel} + (DIV_W+1)'(1)) >> 1);
  assign bit_end  = busy_q && (cnt_q == div_q - DIV_W'(1));

  always_comb begin
    if (accept)       cnt_d = '0;
    else if (busy_q)  cnt_d = bit_end ? '0 : cnt_q + DIV_W'(1);
    else              cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= DIV_MIN;
      sync_q <= 1'b0;
      cnt_q  <= '0;
      p_q    <= 1'b0;
    end else begin
      if (accept) begin
        div_q  <= div_eff;
        sync_q <= sync_in;
      end
      cnt_q <= cnt_d;
      p_q   <= busy_d && sync_sel && (cnt_d < hi_len);
    end
  end

  always_ff @(negedge clk) begin
    if (rst) n_q <= 1'b0;
    else     n_q <= p_q;
  end

  assign bit_clk = div_q[0] ? (p_q & n_q) : p_q;

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cnt_q < div_q);

  // R9
  async_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_q |-> !p_q);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import serial_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [MAX_DATA-1:0]  load_data,
  input  logic                 start,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [CNT_W-1:0]     nbits,
  input  logic                 bit_end,
  output logic [MAX_DATA-1:0]  hold,
  output logic                 accept,
  output logic                 busy_d,
  output logic                 busy,
  output logic                 txd,
  output logic                 done,
  output logic                 irq
);
  logic [MAX_DATA-1:0]  hold_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [CNT_W-1:0]     left_q;
  logic                 loaded_q, busy_q, txd_q, done_q, irq_q, last_bit;

  assign accept   = start && !busy_q && loaded_q;
  assign last_bit = bit_end && (left_q == '0);
  assign busy_d   = accept || (busy_q && !last_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      sh_q     <= '1;
      left_q   <= '0;
      loaded_q <= 1'b0;
      busy_q   <= 1'b0;
      txd_q    <= 1'b1;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (busy_q) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          irq_q  <= 1'b1;
          txd_q  <= 1'b1;
        end else if (bit_end) begin
          txd_q  <= sh_q[0];
          sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
          left_q <= left_q - CNT_W'(1);
        end
      end else if (accept) begin
        txd_q    <= frame[0];
        sh_q     <= {1'b1, frame[FRAME_MAX-1:1]};
        left_q   <= nbits - CNT_W'(1);
        busy_q   <= 1'b1;
        loaded_q <= 1'b0;
      end else if (load) begin
        hold_q   <= load_data;
        loaded_q <= 1'b1;
        done_q   <= 1'b0;
      end
    end
  end

  assign hold = hold_q;
  assign busy = busy_q;
  assign txd  = txd_q;
  assign done = done_q;
  assign irq  = irq_q;

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !txd_q);

  // R7
  hold_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q && load |=> $stable(hold_q));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> irq_q && !busy_q);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import serial_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_DATA-1:0] load_data,
  input  logic                start,
  input  logic [2:0]          len_sel,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic                sync_en,
  input  logic [DIV_W-1:0]    divisor,
  output logic                txd,
  output logic                bit_clk,
  output logic                busy,
  output logic                done,
  output logic                irq
);
  frame_cfg_t           cfg;
  logic [MAX_DATA-1:0]  hold;
  logic [FRAME_MAX-1:0] frame;
  logic [CNT_W-1:0]     nbits;
  logic                 accept, busy_d, bit_end;

  assign cfg = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd,
                 two_stop: two_stop};

  tx_frame_builder u_build (
    .cfg   (cfg),
    .data  (hold),
    .frame (frame),
    .nbits (nbits)
  );

  tx_frame_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (load_data),
    .start     (start),
    .frame     (frame),
    .nbits     (nbits),
    .bit_end   (bit_end),
    .hold      (hold),
    .accept    (accept),
    .busy_d    (busy_d),
    .busy      (busy),
    .txd       (txd),
    .done      (done),
    .irq       (irq)
  );

  tx_baud_phase #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .div_in  (divisor),
    .sync_in (sync_en),
    .busy_q  (busy),
    .busy_d  (busy_d),
    .bit_end (bit_end),
    .bit_clk (bit_clk)
  );
endmodule

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/100ps
module test_serial_frame_tx;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0, start = 1'b0;
  logic [8:0] load_data = '0;
  logic [2:0] len_sel = '0;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, sync_en = 1'b0;
  logic [DIV_W-1:0] divisor = 16'd4;
  logic txd, bit_clk, busy, done, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  serial_frame_tx #(.DIV_W(DIV_W)) i_serial_frame_tx (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data), .start(start),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .sync_en(sync_en), .divisor(divisor), .txd(txd), .bit_clk(bit_clk),
    .busy(busy), .done(done), .irq(irq)
  );

  // Behavioural reference model
  int   q[$];
  bit   m_busy, m_loaded, m_done, m_irq, m_txd = 1'b1, m_p, m_pprev, m_odd, m_sync;
  int   m_cnt, m_div;
  logic [8:0] m_hold;

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic void build_frame();
    int n, d, ones;
    bit bits[$];
    n = (len_sel > 3'd4) ? 9 : int'(len_sel) + 5;
    d = (divisor < 2) ? 2 : int'(divisor);
    bits.push_back(1'b0);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      bits.push_back(m_hold[i]);
      if (m_hold[i]) ones++;
    end
    if (par_en) bits.push_back(par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1));
    bits.push_back(1'b1);
    if (two_stop) bits.push_back(1'b1);
    q.delete();
    foreach (bits[b]) for (int k = 0; k < d; k++) q.push_back(int'(bits[b]));
    m_div  = d;
    m_odd  = (d % 2) == 1;
    m_sync = sync_en;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      q.delete();
      m_busy = 0; m_loaded = 0; m_done = 0; m_irq = 0; m_txd = 1;
      m_p = 0; m_pprev = 0; m_odd = 0; m_sync = 0; m_cnt = 0; m_div = 2;
      m_hold = '0;
    end else begin
      m_pprev = m_p;
      m_irq = 0;
      if (m_busy) begin
        if (q.size() == 0) begin
          m_busy = 0; m_done = 1; m_irq = 1; m_txd = 1; m_p = 0;
        end else begin
          m_txd = q.pop_front() != 0;
          m_cnt = (m_cnt + 1) % m_div;
          m_p   = m_sync && (m_cnt < (m_div + 1) / 2);
        end
      end else if (start && m_loaded) begin
        build_frame();
        m_txd = q.pop_front() != 0;
        m_cnt = 0; m_busy = 1; m_loaded = 0;
        m_p = m_sync;
      end else if (load) begin
        m_hold = load_data; m_loaded = 1; m_done = 0;
      end
    end
    #1;
    if (!rst) begin
      check(txd, m_txd, "R2 R3 R4 R5 R6 txd");
      check(busy, m_busy, "R7 busy");
      check(done, m_done, "R8 done");
      check(irq, m_irq, "R8 irq");
      check(bit_clk, m_odd ? (m_p & m_pprev) : m_p, "R9 bit_clk rising");
    end
  end

  always @(negedge clk) begin
    #1;
    if (!rst) check(bit_clk, m_p, "R9 bit_clk falling");
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse_load(input logic [8:0] d);
    @(negedge clk); load = 1; load_data = d;
    @(negedge clk); load = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (m_busy && guard < 5000);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int len, input bit pe,
                      input bit po, input bit ts, input bit sy, input int dv);
    @(negedge clk);
    len_sel = 3'(len); par_en = pe; par_odd = po; two_stop = ts;
    sync_en = sy; divisor = DIV_W'(dv);
    pulse_load(d);
    pulse_start();
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(txd, 1, "R1 txd idle");
    check(busy, 0, "R1 busy idle");
    check(done, 0, "R1 done idle");
    check(irq, 0, "R1 irq idle");
    check(bit_clk, 0, "R1 bit_clk idle");

    // R10 start with nothing loaded is ignored
    pulse_start();
    check(busy, 0, "R10 start without data");

    send(9'h0A5, 3, 0, 0, 0, 0, 4);   // 8 bits, no parity, 1 stop, async
    check(done, 1, "R8 done after frame");
    send(9'h013, 0, 1, 0, 1, 1, 3);   // 5 bits even parity, 2 stop, sync odd div
    send(9'h1C6, 4, 1, 1, 0, 1, 5);   // 9 bits odd parity, sync
    send(9'h05B, 2, 1, 0, 0, 1, 0);   // 7 bits, divisor 0 -> 2 (R6)
    send(9'h1FF, 6, 1, 1, 1, 1, 6);   // code 6 -> 9 bits (R3)
    send(9'h000, 1, 1, 1, 0, 0, 7);   // 6 bits zeros, odd parity

    // R7 load and start during busy are ignored
    @(negedge clk); len_sel = 3'd3; par_en = 0; two_stop = 0; sync_en = 1; divisor = 16'd4;
    pulse_load(9'h03C);
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_load(9'h0FF);
    pulse_start();
    wait_idle();
    pulse_start();
    repeat (2) @(negedge clk);
    check(busy, 0, "R7 busy load dropped");

    // R8 done stays until next load
    check(done, 1, "R8 done sticky");
    // R10 start and load together: start wins, load dropped
    pulse_load(9'h055);
    check(done, 0, "R2 load clears done");
    @(negedge clk); start = 1; load = 1; load_data = 9'h0AA;
    @(negedge clk); start = 0; load = 0;
    wait_idle();
    pulse_start();
    repeat (2) @(negedge clk);
    check(busy, 0, "R10 same-cycle load dropped");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule